// File: doc/BRIEF.md
# Strip-Pair Coincidence Hit Filter

This block sits behind the discriminators of a two-layer strip tracking module. The module has two sensor planes stacked close together. Each long strip on the upper plane covers a contiguous group of short strips on the lower plane. A track that is stiff enough to count as high momentum crosses both planes at nearly the same place, so it leaves a hit on an upper strip and a hit in the lower group directly beneath it. Hits that show up on only one plane are treated as low-momentum or noise and are thrown away. The upstream logic presents one event per bunch-crossing clock.

On every accepted event the filter registers both planes. It forms one coincidence bit per upper strip and holds that vector for one cycle with a strobe. It then serialises the addresses of the coincident upper strips, lowest address first, and closes the list with an end-of-event marker. A downstream track-vector stage consumes that list. A configuration input widens the match window on the lower plane by a set number of neighbour strips on each side of the group. While a list is still being drained, the filter reports busy. Any event offered during that time is discarded, and a saturating counter records it.

Top module: `strip_coin_filter`

## Requirements
- R1: With `cfg_wide` low, `coin_bits[i]` is 1 exactly when `up_hits[i]` is 1 and at least one of `lo_hits[GRP*i]` through `lo_hits[GRP*i+GRP-1]` is 1.
- R2: With `cfg_wide` high, the lower window of upper strip i grows by NB strips on each side, so it spans `lo_hits[GRP*i-NB]` through `lo_hits[GRP*i+GRP-1+NB]`. Indices below 0 or above the last lower strip count as no hit.
- R3: A hit on only one plane never yields a coincidence bit or an address. This holds for upper hits with no lower hit and for lower hits with no upper hit.
- R4: An event is accepted when `evt_valid` is 1 at a rising edge while `busy` is 0. `coin_valid` is 1 in exactly the cycle that follows that edge, and `coin_bits` shows that event's result from that cycle on.
- R5: Starting in the `coin_valid` cycle, the block emits one coincident address per cycle on `addr_out`, with `addr_valid` high, in strictly ascending order. The list is followed by a single cycle with `addr_eoe` high and `addr_valid` low.
- R6: An event with no coincidence emits only the end-of-event marker, and it does so in its `coin_valid` cycle.
- R7: `busy` is 1 from the `coin_valid` cycle through the end-of-event cycle and 0 after it. An event offered while `busy` is 1 raises no `coin_valid`, leaves `coin_bits` unchanged and adds 1 to `drop_count`.
- R8: `drop_count` saturates at its all-ones value.
- R9: After reset, `coin_bits`, `coin_valid`, `addr_valid`, `addr_eoe`, `busy` and `drop_count` are all 0.
- R10: `cfg_wide` is sampled together with the hits at the accepting edge. Changing it later does not alter that event's `coin_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 selects the neighbour-widened lower window |
| evt_valid | input | 1 | Hits on both planes are valid this cycle |
| up_hits | input | N_UP | Upper-plane long-strip hit bits |
| lo_hits | input | N_UP*GRP | Lower-plane short-strip hit bits, group i at bits GRP*i upward |
| coin_bits | output | N_UP | Coincidence vector of the last accepted event |
| coin_valid | output | 1 | One-cycle strobe for a new coin_bits |
| addr_valid | output | 1 | addr_out holds a coincident strip address |
| addr_out | output | $clog2(N_UP) | Coincident upper-strip address |
| addr_eoe | output | 1 | End-of-event marker for the address list |
| busy | output | 1 | Address list is still being drained |
| drop_count | output | DROP_W | Saturating count of discarded events |

## Verification
The bench builds the filter with N_UP=8, GRP=5, NB=1 and DROP_W=3. Eight upper strips bring both edge strips and a fully populated list within one short table of vectors. They also keep the 40 lower-strip vectors readable by hand. A 3-bit drop counter reaches saturation after a few back-to-back events, so R8 can be checked directly. The neighbour width of one keeps the rule that only the adjacent strip of the neighbouring group is accepted, and a strip two positions away is checked and rejected.

// File: rtl/scf_pkg.sv
// Shared defaults for the strip-pair coincidence filter.
// Assumes the lower plane holds exactly GRP short strips per upper long strip.
package scf_pkg;
    localparam int DEF_N_UP   = 64;  // upper long strips
    localparam int DEF_GRP    = 5;   // lower short strips under one long strip
    localparam int DEF_NB     = 1;   // neighbour strips added per side in wide mode
    localparam int DEF_DROP_W = 16;  // width of the discarded-event counter
endpackage

// File: rtl/scf_cell.sv
// One coincidence cell: ANDs an upper-strip hit with the OR of its lower window.
// The window carries NB left neighbours, GRP direct strips, NB right neighbours,
// in that order from bit 0. Assumes NB >= 1; absent neighbours arrive as 0.
module scf_cell #(
    parameter int GRP = 5,
    parameter int NB  = 1,
    localparam int WIN = GRP + 2 * NB
) (
    input  logic           up_hit,
    input  logic [WIN-1:0] win,
    input  logic           wide,
    output logic           coin
);
    logic direct_any;
    logic nbr_any;

    // Reduce the direct group and the two neighbour flanks separately.
    always_comb begin
        direct_any = |win[NB +: GRP];
        nbr_any    = (|win[0 +: NB]) | (|win[NB+GRP +: NB]);
        coin       = up_hit & (direct_any | (wide & nbr_any));
    end
endmodule

// File: rtl/scf_prio_enc.sv
// Lowest-set-bit encoder used to pick the next address of the sparse list.
// Assumes W >= 2; idx is 0 when no bit is set (any = 0).
module scf_prio_enc #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top down so the last match is the lowest set bit.
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // R5: the chosen bit is set and no lower bit is set.
    always_comb begin
        if (any) begin
            p_enc_lowest_r5: assert (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0))
                else $error("encoder picked a bit that is not the lowest set bit");
        end
    end
endmodule

// File: rtl/strip_coin_filter.sv
// Strip-pair coincidence filter: registers both planes on an accepted event,
// outputs the coincidence vector one cycle later and serialises the coincident
// upper-strip addresses in ascending order, closing with an end-of-event marker.
// Assumes N_UP >= 2, NB >= 1, and lower group i at lo_hits[GRP*i +: GRP].
module strip_coin_filter #(
    parameter int N_UP   = scf_pkg::DEF_N_UP,
    parameter int GRP    = scf_pkg::DEF_GRP,
    parameter int NB     = scf_pkg::DEF_NB,
    parameter int DROP_W = scf_pkg::DEF_DROP_W,
    localparam int N_LO  = N_UP * GRP,
    localparam int AW    = $clog2(N_UP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              evt_valid,
    input  logic [N_UP-1:0]   up_hits,
    input  logic [N_LO-1:0]   lo_hits,
    output logic [N_UP-1:0]   coin_bits,
    output logic              coin_valid,
    output logic              addr_valid,
    output logic [AW-1:0]     addr_out,
    output logic              addr_eoe,
    output logic              busy,
    output logic [DROP_W-1:0] drop_count
);
    localparam int WIN = GRP + 2 * NB;
    localparam int PADW = N_LO + 2 * NB;
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic [PADW-1:0] lo_pad;
    logic [N_UP-1:0] coin_now;
    logic [N_UP-1:0] coin_q;
    logic [N_UP-1:0] pend_q;
    logic            cv_q;
    logic            active_q;
    logic            accept;
    logic [AW-1:0]   next_idx;
    logic            pend_any;
    logic [DROP_W-1:0] drop_q;

    // Pad the lower plane with zeros so edge strips see no missing neighbours.
    assign lo_pad = {{NB{1'b0}}, lo_hits, {NB{1'b0}}};

    // Accept a new event only when no list is being drained.
    assign accept = evt_valid & ~active_q;

    // One cell per upper strip, each looking at its padded lower window.
    for (genvar g = 0; g < N_UP; g++) begin : g_cell
        scf_cell #(.GRP(GRP), .NB(NB)) u_cell (
            .up_hit (up_hits[g]),
            .win    (lo_pad[g*GRP +: WIN]),
            .wide   (cfg_wide),
            .coin   (coin_now[g])
        );
    end

    // Register the coincidence vector and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coin_q <= '0;
            cv_q   <= 1'b0;
        end else begin
            cv_q <= accept;
            if (accept) coin_q <= coin_now;
        end
    end

    // Drain the pending vector one lowest bit per cycle, then one marker cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pend_q   <= '0;
        end else if (accept) begin
            active_q <= 1'b1;
            pend_q   <= coin_now;
        end else if (active_q) begin
            if (pend_any) pend_q <= pend_q & (pend_q - N_UP'(1));
            else          active_q <= 1'b0;
        end
    end

    // Count events offered while busy, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    drop_q <= '0;
        else if (evt_valid && active_q && drop_q != DROP_MAX) drop_q <= drop_q + DROP_W'(1);
    end

    scf_prio_enc #(.W(N_UP)) u_enc (
        .vec (pend_q),
        .idx (next_idx),
        .any (pend_any)
    );

    assign coin_bits  = coin_q;
    assign coin_valid = cv_q;
    assign addr_valid = active_q & pend_any;
    assign addr_out   = next_idx;
    assign addr_eoe   = active_q & ~pend_any;
    assign busy       = active_q;
    assign drop_count = drop_q;

    // R4: an accepted event raises the strobe on the next cycle.
    p_strobe_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !busy |=> coin_valid);

    // R7: an event offered while busy raises no strobe.
    p_drop_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && busy |=> !coin_valid);

    // R7: a discarded event adds one to the counter below saturation.
    p_drop_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && busy && drop_count != DROP_MAX |=> drop_count == $past(drop_count) + DROP_W'(1));

    // R8: a saturated counter stays saturated.
    p_drop_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count == DROP_MAX |=> drop_count == DROP_MAX);

    // R5: consecutive addresses of one list strictly ascend.
    p_addr_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid || addr_out > $past(addr_out));

    // R5: an emitted address is a coincident strip, never together with the marker.
    p_addr_is_coin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> coin_bits[addr_out] && !addr_eoe);

    // R7: the end-of-event marker releases busy on the next cycle.
    p_eoe_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_eoe |=> !busy);
endmodule

// File: tb/sim_strip_coin_filter.sv
// Bench for strip_coin_filter: table of events walked by one loop, then directed tests.
module sim_strip_coin_filter;
    localparam int N_UP = 8;
    localparam int GRP = 5;
    localparam int NB = 1;
    localparam int DROP_W = 3;
    localparam int N_LO = N_UP * GRP;
    localparam int AW = $clog2(N_UP);

    typedef struct packed {
        logic [1:0]      kind;   // 1: R1, 2: R2, 3: R3
        logic            wide;
        logic [N_UP-1:0] up;
        logic [N_LO-1:0] lo;
        logic [N_UP-1:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{2'd3, 1'b0, 8'hFF, 40'h0000000000, 8'h00},  // upper only
        '{2'd3, 1'b0, 8'h00, 40'hFFFFFFFFFF, 8'h00},  // lower only
        '{2'd1, 1'b0, 8'h05, 40'h0000001010, 8'h05},  // strips 0,2 direct hits
        '{2'd1, 1'b0, 8'h02, 40'h0000000410, 8'h00},  // neighbours only, strict
        '{2'd2, 1'b1, 8'h02, 40'h0000000410, 8'h02},  // neighbours, wide
        '{2'd2, 1'b1, 8'h81, 40'h0400000020, 8'h81},  // edge strips via neighbours
        '{2'd2, 1'b1, 8'h80, 40'h0200000000, 8'h00},  // two strips away: no match
        '{2'd1, 1'b0, 8'hFF, 40'hFFFFFFFFFF, 8'hFF}   // every strip coincident
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wide = 1'b0;
    logic evt_valid = 1'b0;
    logic [N_UP-1:0] up_hits = '0;
    logic [N_LO-1:0] lo_hits = '0;
    logic [N_UP-1:0] coin_bits;
    logic coin_valid, addr_valid, addr_eoe, busy;
    logic [AW-1:0] addr_out;
    logic [DROP_W-1:0] drop_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strip_coin_filter #(.N_UP(N_UP), .GRP(GRP), .NB(NB), .DROP_W(DROP_W)) u0 (
        .clk, .rst_n, .cfg_wide, .evt_valid, .up_hits, .lo_hits,
        .coin_bits, .coin_valid, .addr_valid, .addr_out, .addr_eoe, .busy, .drop_count
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one event when idle and follow its strobe, address list and marker.
    task automatic run_evt(input vec_t v, input string req);
        while (busy) @(negedge clk);
        up_hits = v.up; lo_hits = v.lo; cfg_wide = v.wide; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        chk("R4 coin_valid after accept", 64'(coin_valid), 64'd1);
        chk(req, 64'(coin_bits), 64'(v.exp));
        for (int k = 0; k < N_UP; k++) begin
            if (v.exp[k]) begin
                chk("R5 addr_valid", 64'(addr_valid), 64'd1);
                chk("R5 ascending addr", 64'(addr_out), 64'(k));
                chk("R7 busy during list", 64'(busy), 64'd1);
                @(negedge clk);
            end
        end
        chk(v.exp == '0 ? "R6 marker only" : "R5 marker", 64'(addr_eoe), 64'd1);
        chk("R5 no addr with marker", 64'(addr_valid), 64'd0);
        chk("R4 strobe lasts one cycle", 64'(coin_valid), 64'(v.exp == '0));
        @(negedge clk);
        chk("R7 busy clears after marker", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 coin_bits", 64'(coin_bits), 64'd0);
        chk("R9 coin_valid", 64'(coin_valid), 64'd0);
        chk("R9 addr_valid", 64'(addr_valid), 64'd0);
        chk("R9 addr_eoe", 64'(addr_eoe), 64'd0);
        chk("R9 busy", 64'(busy), 64'd0);
        chk("R9 drop_count", 64'(drop_count), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_evt(TBL[i], TBL[i].kind == 2'd1 ? "R1 strict window" :
                            TBL[i].kind == 2'd2 ? "R2 wide window" : "R3 single plane");
        end

        // R10: cfg_wide changed after the accepting edge leaves the result alone.
        up_hits = 8'h02; lo_hits = 40'h0000000410; cfg_wide = 1'b1; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; cfg_wide = 1'b0;
        @(negedge clk);
        chk("R10 cfg sampled at accept", 64'(coin_bits), 64'h02);
        while (busy) @(negedge clk);

        // R7: events offered while busy are discarded.
        up_hits = 8'h07; lo_hits = 40'h0000000421; cfg_wide = 1'b0; evt_valid = 1'b1;
        @(negedge clk);
        up_hits = 8'hF0; lo_hits = '1;
        chk("R7 busy after accept", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R7 no strobe on drop", 64'(coin_valid), 64'd0);
        @(negedge clk);
        evt_valid = 1'b0;
        chk("R7 drop_count", 64'(drop_count), 64'd2);
        while (busy) @(negedge clk);
        chk("R7 dropped event leaves coin_bits", 64'(coin_bits), 64'h07);

        // R8: keep offering events until the counter saturates.
        up_hits = 8'h07; lo_hits = 40'h0000000421; evt_valid = 1'b1;
        repeat (12) @(negedge clk);
        evt_valid = 1'b0;
        chk("R8 drop_count saturates", 64'(drop_count), 64'd7);
        repeat (6) @(negedge clk);
        chk("R8 drop_count holds", 64'(drop_count), 64'd7);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule